// File: doc/BRIEF.md
# Per-Channel Baseline Tracker with Zero Suppression

This block keeps a learned pedestal for each readout channel, with a separate value for the high-gain path and the low-gain path of every channel. Samples arrive one per cycle. Each sample carries a channel number, a gain tag, a 12-bit amplitude and a mode flag. While the mode flag selects free-running acquisition, every accepted sample moves its channel's pedestal towards the sample. The update is a first-order low-pass step with a programmable shift. Free-running samples produce no output.

When the mode flag selects triggered acquisition, the pedestals stay frozen. Each held sample is compared with its own pedestal plus a threshold, and there is one threshold for each gain. A sample that passes is forwarded with the pedestal subtracted. A channel that has not yet learned its pedestal from 1024 free-running samples is forwarded unconditionally, and its output is marked as not calibrated. An enable mask removes unused channels completely.

Top module: `blt_top`

## Requirements
- R1: After reset, `out_valid` is 0, every pedestal is 0 and every channel/gain pair is uncalibrated.
- R2: A free-running sample (`in_trig_mode`=0) on an accepted channel updates that pair's pedestal as b <= b + ((x*1024 - b) >>> k). Here b is an unsigned value with 12 integer and 10 fractional bits, and k is `cfg_shift` clamped to at most 10. Free-running samples never produce output.
- R3: A triggered sample (`in_trig_mode`=1) never changes any pedestal or any sample count.
- R4: For a calibrated pair, a triggered sample is forwarded only if x > floor(b) + T. The sum is computed without wrap-around, and T is `cfg_thr_hi` for `in_gain`=1 and `cfg_thr_lo` for `in_gain`=0.
- R5: The forwarded `out_amp` is x - floor(b), saturated at 0 when the pedestal exceeds the sample.
- R6: A pair that has accepted fewer than 1024 free-running samples is forwarded on every triggered sample, with `out_uncal`=1. From the 1024th accepted sample onward, `out_uncal`=0 and R4 applies.
- R7: A sample whose channel is 96 or above, or whose bit in `cfg_enable` is 0, produces no output and leaves that channel's pedestal and sample count unchanged.
- R8: The high-gain (`in_gain`=1) and low-gain (`in_gain`=0) values of a channel keep separate pedestals, separate counts and separate thresholds.
- R9: A forwarded result appears one clock after its input sample, with `out_ch` and `out_gain` equal to that sample's channel and gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_ch | input | 7 | Channel number of the sample |
| in_gain | input | 1 | 1 = high gain, 0 = low gain |
| in_data | input | 12 | Sample amplitude |
| in_trig_mode | input | 1 | 1 = triggered (compare), 0 = free-running (learn) |
| cfg_shift | input | 4 | Low-pass shift k, clamped to 10 |
| cfg_thr_lo | input | 12 | Threshold for low-gain samples |
| cfg_thr_hi | input | 12 | Threshold for high-gain samples |
| cfg_enable | input | 96 | Per-channel enable mask |
| out_valid | output | 1 | Forwarded result present |
| out_ch | output | 7 | Channel of the result |
| out_gain | output | 1 | Gain of the result |
| out_amp | output | 12 | Pedestal-subtracted amplitude |
| out_uncal | output | 1 | Result from a pair that is not yet calibrated |

## Verification
The assertions assume that the configuration inputs (`cfg_*`) are stable during the cycle in which a triggered sample is taken. They compare each result with the previous cycle's threshold and mask. They also assume that the mode flag is valid on every cycle that `in_valid` is high. The bench changes the configuration only while `in_valid` is low. It also keeps `in_trig_mode` at a defined level at all times, including during reset, so that the properties that look one cycle back always see defined values.

// File: rtl/blt_pkg.sv
package blt_pkg;
    localparam int CH_W   = 7;
    localparam int DW     = 12;
    localparam int FW     = 10;
    localparam int BW     = DW + FW;
    localparam int SH_W   = 4;
    localparam int SH_MAX = 10;

    typedef enum logic {GAIN_LO = 1'b0, GAIN_HI = 1'b1} gain_e;

    typedef struct packed {
        logic [CH_W-1:0] ch;
        gain_e           gain;
        logic [DW-1:0]   data;
    } smp_t;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] ch;
        gain_e           gain;
        logic [DW-1:0]   amp;
        logic            uncal;
    } res_t;

    // One low-pass step: b + ((x<<FW) - b) >>> k, k clamped to SH_MAX
    function automatic logic [BW-1:0] lp_step(input logic [BW-1:0] b,
                                              input logic [DW-1:0] x,
                                              input logic [SH_W-1:0] k);
        logic signed [BW:0] diff;
        logic signed [BW:0] step;
        logic signed [BW:0] sum;
        logic [SH_W-1:0]    kk;
        kk   = (k > SH_W'(SH_MAX)) ? SH_W'(SH_MAX) : k;
        diff = $signed({1'b0, x, {FW{1'b0}}}) - $signed({1'b0, b});
        step = diff >>> kk;
        sum  = $signed({1'b0, b}) + step;
        return sum[BW-1:0];
    endfunction

    // x - base, clipped at zero
    function automatic logic [DW-1:0] sat_sub(input logic [DW-1:0] x,
                                              input logic [DW-1:0] base);
        logic signed [DW:0] d;
        d = $signed({1'b0, x}) - $signed({1'b0, base});
        return (d < 0) ? '0 : d[DW-1:0];
    endfunction
endpackage

// File: rtl/blt_store.sv
module blt_store
    import blt_pkg::*;
#(
    parameter int NENT  = 192,
    parameter int CAL_N = 1024,
    localparam int IDX_W = $clog2(NENT),
    localparam int CNT_W = $clog2(CAL_N + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    input  logic [SH_W-1:0]  shift,
    output logic [DW-1:0]    rd_base,
    output logic             rd_calib
);
    logic [BW-1:0]    base_q [NENT];
    logic [CNT_W-1:0] cnt_q  [NENT];

    for (genvar i = 0; i < NENT; i++) begin : g_ent
        logic hit;
        assign hit = we && (idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i] <= '0;
                cnt_q[i]  <= '0;
            end else if (hit) begin
                base_q[i] <= lp_step(base_q[i], wdata, shift);
                if (cnt_q[i] != CNT_W'(CAL_N))
                    cnt_q[i] <= cnt_q[i] + 1'b1;
            end
        end
    end

    assign rd_base  = base_q[idx][BW-1:FW];
    assign rd_calib = (cnt_q[idx] == CNT_W'(CAL_N));
endmodule

// File: rtl/blt_judge.sv
module blt_judge
    import blt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  smp_t          smp,
    input  logic [DW-1:0] base,
    input  logic          calib,
    input  logic [DW-1:0] thr,
    output res_t          res
);
    logic [DW:0] limit;
    logic        exceed;
    logic        hit;

    assign limit  = {1'b0, base} + {1'b0, thr};
    assign exceed = {1'b0, smp.data} > limit;
    assign hit    = req && (!calib || exceed);

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.valid <= hit;
            if (hit) begin
                res.ch    <= smp.ch;
                res.gain  <= smp.gain;
                res.amp   <= sat_sub(smp.data, base);
                res.uncal <= !calib;
            end
        end
    end
endmodule

// File: rtl/blt_top.sv
module blt_top
    import blt_pkg::*;
#(
    parameter int NCH   = 96,
    parameter int CAL_N = 1024,
    localparam int NENT  = 2 * NCH,
    localparam int IDX_W = $clog2(NENT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [CH_W-1:0] in_ch,
    input  logic            in_gain,
    input  logic [DW-1:0]   in_data,
    input  logic            in_trig_mode,
    input  logic [SH_W-1:0] cfg_shift,
    input  logic [DW-1:0]   cfg_thr_lo,
    input  logic [DW-1:0]   cfg_thr_hi,
    input  logic [NCH-1:0]  cfg_enable,
    output logic            out_valid,
    output logic [CH_W-1:0] out_ch,
    output logic            out_gain,
    output logic [DW-1:0]   out_amp,
    output logic            out_uncal
);
    smp_t            smp;
    res_t            res;
    logic            in_range;
    logic [CH_W-1:0] ch_safe;
    logic            accept;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]   base;
    logic            calib;
    logic [DW-1:0]   thr;

    assign smp.ch   = in_ch;
    assign smp.gain = gain_e'(in_gain);
    assign smp.data = in_data;

    assign in_range = (32'(in_ch) < NCH);
    assign ch_safe  = in_range ? in_ch : '0;
    assign accept   = in_valid && in_range && cfg_enable[ch_safe];
    assign idx      = IDX_W'({ch_safe, in_gain});
    assign thr      = in_gain ? cfg_thr_hi : cfg_thr_lo;

    blt_store #(.NENT(NENT), .CAL_N(CAL_N)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (accept && !in_trig_mode),
        .idx     (idx),
        .wdata   (in_data),
        .shift   (cfg_shift),
        .rd_base (base),
        .rd_calib(calib)
    );

    blt_judge u_judge (
        .clk  (clk),
        .rst  (rst),
        .req  (accept && in_trig_mode),
        .smp  (smp),
        .base (base),
        .calib(calib),
        .thr  (thr),
        .res  (res)
    );

    assign out_valid = res.valid;
    assign out_ch    = res.ch;
    assign out_gain  = res.gain;
    assign out_amp   = res.amp;
    assign out_uncal = res.uncal;
endmodule

// File: rtl/blt_chk.sv
module blt_chk #(
    parameter int NCH = 96
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [6:0]     in_ch,
    input logic           in_gain,
    input logic [11:0]    in_data,
    input logic           in_trig_mode,
    input logic [11:0]    cfg_thr_lo,
    input logic [11:0]    cfg_thr_hi,
    input logic [NCH-1:0] cfg_enable,
    input logic           out_valid,
    input logic [6:0]     out_ch,
    input logic           out_gain,
    input logic [11:0]    out_amp,
    input logic           out_uncal
);
    // R2 / R9: output only follows a triggered sample one cycle earlier
    assert_out_needs_trig_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_trig_mode));

    // R7: result comes from an in-range, enabled channel
    assert_enabled_only_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(32'(in_ch) < NCH) && $past(cfg_enable[in_ch])));

    // R9: tags follow the input sample
    assert_tags_follow_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_ch == $past(in_ch) && out_gain == $past(in_gain)));

    // R4: a calibrated result exceeds its threshold
    assert_above_thr_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_uncal) |->
            (out_amp > $past(in_gain ? cfg_thr_hi : cfg_thr_lo)));

    // R5: subtracted amplitude never exceeds the raw sample
    assert_amp_bound_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_amp <= $past(in_data)));
endmodule

bind blt_top blt_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch),
    .in_gain(in_gain), .in_data(in_data), .in_trig_mode(in_trig_mode),
    .cfg_thr_lo(cfg_thr_lo), .cfg_thr_hi(cfg_thr_hi), .cfg_enable(cfg_enable),
    .out_valid(out_valid), .out_ch(out_ch), .out_gain(out_gain),
    .out_amp(out_amp), .out_uncal(out_uncal)
);

// File: tb/blt_top_tb.sv
module blt_top_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic [6:0]  in_ch = 0;
    logic        in_gain = 0;
    logic [11:0] in_data = 0;
    logic        in_trig_mode = 0;
    logic [3:0]  cfg_shift = 0;
    logic [11:0] cfg_thr_lo = 50;
    logic [11:0] cfg_thr_hi = 20;
    logic [95:0] cfg_enable = '1;
    logic        out_valid;
    logic [6:0]  out_ch;
    logic        out_gain;
    logic [11:0] out_amp;
    logic        out_uncal;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    blt_top u_dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one sample; outputs sampled 1 ns after the capturing edge
    task automatic xfer(input int ch, input bit g, input int d, input bit trig);
        @(negedge clk);
        in_valid = 1; in_ch = 7'(ch); in_gain = g; in_data = 12'(d); in_trig_mode = trig;
        @(posedge clk); #1;
        in_valid = 0; in_trig_mode = 0;
    endtask

    task automatic learn(input int ch, input bit g, input int d, input int n);
        for (int i = 0; i < n; i++) xfer(ch, g, d, 0);
    endtask

    // trigger and check the full result
    task automatic expect_out(input string tag, input int ch, input bit g, input int d,
                              input bit ev, input int amp, input bit unc);
        xfer(ch, g, d, 1);
        check(out_valid == ev, {tag, " valid"}, out_valid, ev);
        if (ev && out_valid) begin
            check(out_amp == 12'(amp), {tag, " amp"}, out_amp, amp);
            check(out_uncal == unc, {tag, " uncal"}, out_uncal, unc);
            check(out_ch == 7'(ch) && out_gain == g, {tag, " tags R9"}, out_ch, ch);
        end
    endtask

    // {ch7, gain1, data12, exp_valid1, exp_amp12, exp_uncal1}
    localparam logic [33:0] VEC [9] = '{
        {7'd5,  1'b1, 12'd121,  1'b1, 12'd21,   1'b0},  // R4 just above
        {7'd5,  1'b1, 12'd120,  1'b0, 12'd0,    1'b0},  // R4 equal: dropped
        {7'd5,  1'b1, 12'd50,   1'b0, 12'd0,    1'b0},  // R4 below
        {7'd5,  1'b1, 12'd4095, 1'b1, 12'd3995, 1'b0},  // R4/R5 top of range
        {7'd5,  1'b0, 12'd351,  1'b1, 12'd51,   1'b0},  // R8 low gain own thr
        {7'd5,  1'b0, 12'd350,  1'b0, 12'd0,    1'b0},  // R8 low gain equal
        {7'd9,  1'b1, 12'd7,    1'b1, 12'd7,    1'b1},  // R6 untouched pair
        {7'd96, 1'b1, 12'd900,  1'b0, 12'd0,    1'b0},  // R7 out of range
        {7'd7,  1'b1, 12'd900,  1'b0, 12'd0,    1'b0}   // R7 disabled
    };

    initial begin
        cfg_enable[7] = 0;
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 0, "R1 reset valid", out_valid, 0);
        @(negedge clk); rst = 0;

        // R6 boundary: 1023 samples still uncalibrated; R5 clip to 0
        learn(5, 1, 100, 1023);
        expect_out("R6 1023 samples", 5, 1, 90, 1, 0, 1);
        learn(5, 1, 100, 1);
        expect_out("R6 1024 samples", 5, 1, 90, 0, 0, 0);
        learn(5, 0, 300, 1024);
        learn(7, 1, 500, 1024);     // disabled: must not learn (R7)

        foreach (VEC[i]) begin
            expect_out($sformatf("vec%0d", i), int'(VEC[i][33:27]), VEC[i][26],
                       int'(VEC[i][25:14]), VEC[i][13], int'(VEC[i][12:1]), VEC[i][0]);
        end

        // R7: disabled channel learned nothing
        @(negedge clk); cfg_enable[7] = 1;
        expect_out("R7 no learn while masked", 7, 1, 510, 1, 510, 1);

        // R2 shift k=2: one sample 400 -> integer pedestal 100
        @(negedge clk); cfg_shift = 2;
        learn(11, 1, 400, 1);
        expect_out("R2 shift2", 11, 1, 150, 1, 50, 1);
        expect_out("R3 frozen", 11, 1, 150, 1, 50, 1);
        expect_out("R5 clip", 11, 1, 30, 1, 0, 1);

        // R2 clamp: shift 15 acts as 10, sample 1024 -> pedestal 1
        @(negedge clk); cfg_shift = 15;
        learn(12, 1, 1024, 1);
        expect_out("R2 clamp", 12, 1, 10, 1, 9, 1);

        // R2 free-running produces nothing
        xfer(13, 1, 4000, 0);
        check(out_valid == 0, "R2 no output free-run", out_valid, 0);

        // R1 reset clears learned state
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        expect_out("R1 reset clears", 5, 1, 90, 1, 90, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule